// File: doc/BRIEF.md
# Card Command and Response Controller

This block sends one command to a storage card and collects the reply. Software writes a 32-bit argument and then a command word. The command word holds a 6-bit index, the response type and an enable flag. The block presents the index and the argument on an abstract card-side handshake and waits for the card to acknowledge. The acknowledge carries a reply length in bytes and up to sixteen reply bytes. The block checks the length against the response type that was asked for. It packs valid replies into four 32-bit response words and records the outcome in a sticky status word.

Software acknowledges events through a write-one-to-clear register. Two independent mask registers each gate the status word onto one interrupt line. A programmable wait limit guards the handshake, so a card that never answers produces a timeout. Serial line timing, CRC and the data path are outside this block.

Top module: `cmdresp_ctrl`

## Requirements
- R1: Register map at word addresses on `reg_addr`: 0 argument, 1 command, 2 to 5 response words 0 to 3, 6 status (read only), 7 clear (write only), 8 wait limit (resets to 64), 9 mask 0, 10 mask 1. Reads of all other addresses return 0. Writing the command word with bit 10 (enable) set and bit 9 (pending) clear starts a command while the block is idle. From the next cycle on, `req_valid` is high, `req_index` carries bits 5:0 of the command word and `req_arg` carries the argument.
- R2: The other command bits are bit 6 (response expected), bit 7 (long response) and bit 8 (interrupt mode, stored only). The enable bit reads back as 0 once the command completes, whatever the outcome. A command word written with the pending bit set is stored but never issued, and its enable bit reads back as 0.
- R3: When a response is expected, status bit 2 (timeout) is set if the reply length is 0, or if it is 4 while a long response was asked for, or if it is anything other than 4 or 16.
- R4: Reply bytes are packed most-significant first: byte 0 lands in bits 31:24 of response word 0, byte 3 in bits 7:0, byte 4 in word 1, and so on. Reply byte k arrives on `rsp_data[8k+7:8k]`. A valid 4-byte reply fills word 0 and zeroes words 1 to 3.
- R5: A valid 16-byte reply fills all four response words, with bit 0 of word 3 forced to 0.
- R6: A valid reply sets status bit 6 (response end). A command that expects no response sets status bit 7 (command sent). On a timeout the response words keep their old values. Status bits stay set until cleared.
- R7: Writing the clear register clears exactly the status bits that are 1 in the written value, limited to bits 10:0. Bit 11 is not affected.
- R8: Interrupt output `irq[i]` is high exactly when the status word ANDed with mask register i is nonzero.
- R9: If the card does not acknowledge within the wait limit plus one cycle of issue, the block completes the command as if the reply length were 0.
- R10: While a command is in flight, status bit 11 (command active) reads 1, and writes to the command and argument registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register word address |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from address) |
| req_valid | output | 1 | Command in flight to the card |
| req_index | output | 6 | Command index presented to the card |
| req_arg | output | 32 | Command argument presented to the card |
| rsp_valid | input | 1 | Card acknowledge, one cycle, meaningful while `req_valid` |
| rsp_len | input | 5 | Reply length in bytes |
| rsp_data | input | 128 | Reply bytes, byte k at bits 8k+7:8k |
| irq | output | 2 | Masked status interrupt lines |

## Verification
The assertions check the following on every cycle:
- a valid command write raises the request with the written index;
- the request and the stored command hold steady until an acknowledge or an expiry;
- completion clears the enable bit;
- a pending write never raises the request;
- the clear register removes the written bits;
- short and long replies end with zeroed upper words or a cleared last bit;
- a zero-length or expired reply sets the timeout bit.

Only the bench's scenarios show the following:
- exact byte packing;
- that response words are left untouched on a timeout;
- that status bits accumulate across commands;
- how the two mask registers steer each interrupt line.

// File: rtl/cmdresp_pkg.sv
`timescale 1ns/1ps
package cmdresp_pkg;
    localparam int unsigned REG_W = 32;
    localparam int unsigned CMD_W = 11;

    // register word addresses
    localparam logic [3:0] A_ARG   = 4'd0;
    localparam logic [3:0] A_CMD   = 4'd1;
    localparam logic [3:0] A_RSP0  = 4'd2;
    localparam logic [3:0] A_STAT  = 4'd6;
    localparam logic [3:0] A_CLR   = 4'd7;
    localparam logic [3:0] A_LIMIT = 4'd8;
    localparam logic [3:0] A_MASK0 = 4'd9;

    // command word bit positions
    localparam int unsigned C_IDX_W = 6;
    localparam int unsigned C_RESP  = 6;
    localparam int unsigned C_LONG  = 7;
    localparam int unsigned C_PEND  = 9;
    localparam int unsigned C_EN    = 10;

    // status word bit positions
    localparam int unsigned S_TMO    = 2;
    localparam int unsigned S_RSPEND = 6;
    localparam int unsigned S_SENT   = 7;
    localparam int unsigned S_ACTIVE = 11;

    localparam logic [REG_W-1:0] CLR_SPAN = 32'h0000_07FF;
endpackage

// File: rtl/cmdresp_reply_chk.sv
`timescale 1ns/1ps
module cmdresp_reply_chk #(
    parameter int unsigned NBYTES = 16,
    localparam int unsigned NWORDS = NBYTES / 4,
    localparam int unsigned LEN_W  = $clog2(NBYTES + 1)
) (
    input  logic                          want_long,
    input  logic [LEN_W-1:0]              rlen,
    input  logic [8*NBYTES-1:0]           rbytes,
    output logic                          good,
    output logic [NWORDS-1:0][31:0]       words
);
    logic full_len;
    logic word_len;

    assign full_len = (rlen == LEN_W'(NBYTES));
    assign word_len = (rlen == LEN_W'(4));
    assign good     = full_len || (word_len && !want_long);

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        logic [31:0] raw;
        assign raw = {rbytes[8*(4*w)   +: 8], rbytes[8*(4*w+1) +: 8],
                      rbytes[8*(4*w+2) +: 8], rbytes[8*(4*w+3) +: 8]};
        if (w == 0) begin : g_first
            assign words[w] = raw;
        end else if (w == NWORDS - 1) begin : g_last
            assign words[w] = full_len ? {raw[31:1], 1'b0} : 32'h0;
        end else begin : g_mid
            assign words[w] = full_len ? raw : 32'h0;
        end
    end
endmodule

// File: rtl/cmdresp_wait_timer.sv
`timescale 1ns/1ps
module cmdresp_wait_timer #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = run ? cnt_q + W'(1) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && (cnt_q == limit);
endmodule

// File: rtl/cmdresp_irq.sv
`timescale 1ns/1ps
module cmdresp_irq #(
    parameter int unsigned NUM_IRQ = 2,
    parameter int unsigned SW      = 32
) (
    input  logic [SW-1:0]              status,
    input  logic [NUM_IRQ-1:0][SW-1:0] mask,
    output logic [NUM_IRQ-1:0]         irq
);
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        assign irq[i] = |(status & mask[i]);
    end
endmodule

// File: rtl/cmdresp_ctrl.sv
`timescale 1ns/1ps
module cmdresp_ctrl
    import cmdresp_pkg::*;
#(
    parameter int unsigned RSP_BYTES = 16,
    parameter int unsigned NUM_IRQ   = 2,
    parameter int unsigned TMO_W     = 16,
    parameter int unsigned DEF_LIMIT = 64,
    localparam int unsigned RSP_WORDS = RSP_BYTES / 4,
    localparam int unsigned LEN_W     = $clog2(RSP_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [3:0]             reg_addr,
    input  logic                   reg_wen,
    input  logic [31:0]            reg_wdata,
    output logic [31:0]            reg_rdata,
    output logic                   req_valid,
    output logic [5:0]             req_index,
    output logic [31:0]            req_arg,
    input  logic                   rsp_valid,
    input  logic [4:0]             rsp_len,
    input  logic [127:0]           rsp_data,
    output logic [1:0]             irq
);
    typedef struct packed {
        logic                           busy;
        logic [REG_W-1:0]               arg;
        logic [CMD_W-1:0]               cmd;
        logic [RSP_WORDS-1:0][REG_W-1:0] resp;
        logic [REG_W-1:0]               status;
        logic [NUM_IRQ-1:0][REG_W-1:0]  mask;
        logic [TMO_W-1:0]               limit;
    } regs_t;

    regs_t d, q;

    logic                            tmo_expired;
    logic                            tmo_hit;
    logic                            ack;
    logic [LEN_W-1:0]                eff_len;
    logic                            reply_good;
    logic [RSP_WORDS-1:0][REG_W-1:0] reply_words;

    cmdresp_wait_timer #(.W(TMO_W)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (q.busy),
        .limit   (q.limit),
        .expired (tmo_expired)
    );

    assign ack     = q.busy && rsp_valid;
    assign tmo_hit = tmo_expired && !rsp_valid;
    assign eff_len = ack ? LEN_W'(rsp_len) : '0;

    cmdresp_reply_chk #(.NBYTES(RSP_BYTES)) reply_i (
        .want_long (q.cmd[C_LONG]),
        .rlen      (eff_len),
        .rbytes    (rsp_data[8*RSP_BYTES-1:0]),
        .good      (reply_good),
        .words     (reply_words)
    );

    cmdresp_irq #(.NUM_IRQ(NUM_IRQ), .SW(REG_W)) irq_i (
        .status (q.status),
        .mask   (q.mask),
        .irq    (irq)
    );

    always_comb begin
        d = q;
        if (reg_wen) begin
            if (reg_addr == A_ARG && !q.busy) begin
                d.arg = reg_wdata;
            end
            if (reg_addr == A_CMD && !q.busy) begin
                d.cmd = reg_wdata[CMD_W-1:0];
                if (reg_wdata[C_EN] && !reg_wdata[C_PEND]) begin
                    d.busy = 1'b1;
                end else begin
                    d.cmd[C_EN] = 1'b0;
                end
            end
            if (reg_addr == A_CLR) begin
                d.status = q.status & ~(reg_wdata & CLR_SPAN);
            end
            if (reg_addr == A_LIMIT) begin
                d.limit = reg_wdata[TMO_W-1:0];
            end
            for (int i = 0; i < NUM_IRQ; i++) begin
                if (reg_addr == A_MASK0 + 4'(i)) d.mask[i] = reg_wdata;
            end
        end
        if (ack || tmo_hit) begin
            d.busy      = 1'b0;
            d.cmd[C_EN] = 1'b0;
            if (q.cmd[C_RESP]) begin
                if (reply_good) begin
                    d.resp             = reply_words;
                    d.status[S_RSPEND] = 1'b1;
                end else begin
                    d.status[S_TMO] = 1'b1;
                end
            end else begin
                d.status[S_SENT] = 1'b1;
            end
        end
        d.status[S_ACTIVE] = d.busy;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.limit <= TMO_W'(DEF_LIMIT);
        end else begin
            q <= d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_ARG:   reg_rdata = q.arg;
            A_CMD:   reg_rdata = REG_W'(q.cmd);
            A_STAT:  reg_rdata = q.status;
            A_LIMIT: reg_rdata = REG_W'(q.limit);
            default: reg_rdata = '0;
        endcase
        for (int i = 0; i < RSP_WORDS; i++) begin
            if (reg_addr == A_RSP0 + 4'(i)) reg_rdata = q.resp[i];
        end
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (reg_addr == A_MASK0 + 4'(i)) reg_rdata = q.mask[i];
        end
    end

    assign req_valid = q.busy;
    assign req_index = q.cmd[C_IDX_W-1:0];
    assign req_arg   = q.arg;

    logic [CMD_W-1:0]                cur_cmd;
    logic [REG_W-1:0]                cur_status;
    logic [RSP_WORDS-1:0][REG_W-1:0] cur_resp;
    assign cur_cmd    = q.cmd;
    assign cur_status = q.status;
    assign cur_resp   = q.resp;
endmodule

// File: rtl/cmdresp_ctrl_chk.sv
`timescale 1ns/1ps
module cmdresp_ctrl_chk
    import cmdresp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        reg_addr,
    input logic              reg_wen,
    input logic [31:0]       reg_wdata,
    input logic              req_valid,
    input logic [5:0]        req_index,
    input logic              rsp_valid,
    input logic [4:0]        rsp_len,
    input logic              tmo_hit,
    input logic [10:0]       cur_cmd,
    input logic [31:0]       cur_status,
    input logic [3:0][31:0]  cur_resp
);
    // R1
    issue_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wen && reg_addr == A_CMD && reg_wdata[C_EN] && !reg_wdata[C_PEND] && !req_valid
        |=> req_valid && req_index == $past(reg_wdata[5:0]));

    // R2
    enable_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (rsp_valid || tmo_hit) |=> !cur_cmd[C_EN] && !req_valid);

    // R2
    pending_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wen && reg_addr == A_CMD && reg_wdata[C_PEND] && !req_valid
        |=> !req_valid && !cur_cmd[C_EN]);

    // R3
    zero_len_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && rsp_valid && cur_cmd[C_RESP] && rsp_len == 5'd0 |=> cur_status[S_TMO]);

    // R4
    short_reply_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && rsp_valid && cur_cmd[C_RESP] && !cur_cmd[C_LONG] && rsp_len == 5'd4
        |=> cur_resp[3] == 32'h0 && cur_resp[2] == 32'h0 && cur_resp[1] == 32'h0);

    // R5
    long_reply_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && rsp_valid && cur_cmd[C_RESP] && rsp_len == 5'd16
        |=> !cur_resp[3][0] && cur_status[S_RSPEND]);

    // R7
    clear_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wen && reg_addr == A_CLR && !req_valid
        |=> (cur_status[10:0] & $past(reg_wdata[10:0])) == 11'h0);

    // R9
    expiry_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && tmo_hit && cur_cmd[C_RESP] |=> cur_status[S_TMO]);

    // R10
    inflight_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !rsp_valid && !tmo_hit
        |=> req_valid && cur_status[S_ACTIVE] && $stable(cur_cmd) && $stable(req_index));
endmodule

bind cmdresp_ctrl cmdresp_ctrl_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wen    (reg_wen),
    .reg_wdata  (reg_wdata),
    .req_valid  (req_valid),
    .req_index  (req_index),
    .rsp_valid  (rsp_valid),
    .rsp_len    (rsp_len),
    .tmo_hit    (tmo_hit),
    .cur_cmd    (cur_cmd),
    .cur_status (cur_status),
    .cur_resp   (cur_resp)
);

// File: tb/cmdresp_ctrl_tb_top.sv
`timescale 1ns/1ps
module cmdresp_ctrl_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   reg_addr = '0;
    logic         reg_wen = 1'b0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         req_valid;
    logic [5:0]   req_index;
    logic [31:0]  req_arg;
    logic         rsp_valid = 1'b0;
    logic [4:0]   rsp_len = '0;
    logic [127:0] rsp_data = '0;
    logic [1:0]   irq;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    cmdresp_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_index(req_index), .req_arg(req_arg), .rsp_valid(rsp_valid),
        .rsp_len(rsp_len), .rsp_data(rsp_data), .irq(irq)
    );

    localparam logic [127:0] BYTES = 128'hfffefdfcfbfaf9f8f7f6f5f4f3f2f1f0;

    typedef struct packed {
        logic [10:0] cmd;
        logic [4:0]  len;
        logic [31:0] st;
        logic [31:0] e0;
        logic [31:0] e1;
        logic [31:0] e2;
        logic [31:0] e3;
    } vec_t;

    localparam vec_t VEC [7] = '{
        '{11'h4C2, 5'd16, 32'h40, 32'hf0f1f2f3, 32'hf4f5f6f7, 32'hf8f9fafb, 32'hfcfdfefe},
        '{11'h451, 5'd4,  32'h40, 32'hf0f1f2f3, 32'h0,        32'h0,        32'h0},
        '{11'h4C2, 5'd4,  32'h04, 32'hf0f1f2f3, 32'h0,        32'h0,        32'h0},
        '{11'h445, 5'd0,  32'h04, 32'hf0f1f2f3, 32'h0,        32'h0,        32'h0},
        '{11'h445, 5'd8,  32'h04, 32'hf0f1f2f3, 32'h0,        32'h0,        32'h0},
        '{11'h400, 5'd0,  32'h80, 32'hf0f1f2f3, 32'h0,        32'h0,        32'h0},
        '{11'h440, 5'd16, 32'h40, 32'hf0f1f2f3, 32'hf4f5f6f7, 32'hf8f9fafb, 32'hfcfdfefe}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic reply(input logic [4:0] len);
        rsp_valid = 1'b1; rsp_len = len; rsp_data = BYTES;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state (R1, R8)
        rd(4'd6, v);  check("R1 reset status", v, 32'h0);
        rd(4'd1, v);  check("R1 reset command", v, 32'h0);
        rd(4'd2, v);  check("R1 reset resp0", v, 32'h0);
        rd(4'd8, v);  check("R1 reset limit", v, 32'd64);
        check("R1 reset req_valid", {31'b0, req_valid}, 32'h0);
        check("R8 reset irq", {30'b0, irq}, 32'h0);

        // vector table: R1 R2 R3 R4 R5 R6
        for (int i = 0; i < 7; i++) begin
            wr(4'd7, 32'hFFF);
            wr(4'd0, 32'hA000_0000 + i);
            wr(4'd1, {21'b0, VEC[i].cmd});
            check("R1 req_valid", {31'b0, req_valid}, 32'h1);
            check("R1 req_index", {26'b0, req_index}, {26'b0, VEC[i].cmd[5:0]});
            check("R1 req_arg", req_arg, 32'hA000_0000 + i);
            reply(VEC[i].len);
            rd(4'd6, v); check("R3 R6 status", v, VEC[i].st);
            rd(4'd2, v); check("R4 resp0", v, VEC[i].e0);
            rd(4'd3, v); check("R4 R5 resp1", v, VEC[i].e1);
            rd(4'd4, v); check("R4 R5 resp2", v, VEC[i].e2);
            rd(4'd5, v); check("R5 resp3", v, VEC[i].e3);
            rd(4'd1, v); check("R2 enable cleared", v, {21'b0, 1'b0, VEC[i].cmd[9:0]});
        end

        // R2: pending write stored, never issued
        wr(4'd7, 32'hFFF);
        wr(4'd1, 32'h643);
        repeat (4) begin
            @(negedge clk);
            check("R2 pending no request", {31'b0, req_valid}, 32'h0);
        end
        rd(4'd1, v); check("R2 pending readback", v, 32'h243);

        // R9: no acknowledge, limit 3
        wr(4'd8, 32'd3);
        wr(4'd1, 32'h441);
        repeat (10) @(negedge clk);
        check("R9 request dropped", {31'b0, req_valid}, 32'h0);
        rd(4'd6, v); check("R9 timeout status", v, 32'h04);
        rd(4'd1, v); check("R9 enable cleared", v, 32'h041);

        // R10 and R7 while in flight
        wr(4'd8, 32'd1000);
        wr(4'd7, 32'hFFF);
        wr(4'd0, 32'h0000_5555);
        wr(4'd1, 32'h445);
        rd(4'd6, v); check("R10 active bit", v, 32'h800);
        wr(4'd1, 32'h44A);
        wr(4'd0, 32'h0000_1234);
        rd(4'd1, v); check("R10 command write ignored", v, 32'h445);
        check("R10 index held", {26'b0, req_index}, 32'h5);
        check("R10 argument held", req_arg, 32'h0000_5555);
        wr(4'd7, 32'hFFF);
        rd(4'd6, v); check("R7 bit 11 survives clear", v, 32'h800);
        @(negedge clk);
        reply(5'd4);
        rd(4'd6, v); check("R6 response end", v, 32'h40);

        // R6 sticky accumulation
        wr(4'd1, 32'h407);
        reply(5'd0);
        rd(4'd6, v); check("R6 sticky bits", v, 32'hC0);

        // R8 masks, R7 partial clear
        wr(4'd9, 32'h40);
        wr(4'd10, 32'h04);
        check("R8 irq mask0 only", {30'b0, irq}, 32'h1);
        wr(4'd10, 32'h80);
        check("R8 irq both", {30'b0, irq}, 32'h3);
        wr(4'd7, 32'h40);
        rd(4'd6, v); check("R7 partial clear", v, 32'h80);
        check("R8 irq after clear", {30'b0, irq}, 32'h2);
        wr(4'd7, 32'h80);
        check("R8 irq all clear", {30'b0, irq}, 32'h0);

        finish_run();
    end
endmodule